// File: doc/BRIEF.md
# AHB Shared Data Port with Debug Arbitration

This block sits between a processor's load/store unit and a single AHB5 manager port. The core hands it requests over a valid/ready interface, and each accepted request becomes one single-beat AHB transfer. A second requester, the debugger's system-bus path, shares the same port. The arbiter decides which requester drives each address phase. It records which requester owns the following data phase, so that completion, error, exclusive status and read data return only to that requester.

The address phase is driven combinationally from the winning request, which adds no cycle of latency. Write data is captured when the address phase is accepted. It is copied across all byte lanes to fit the access size and is held on the write bus for the whole data phase. A core exclusive read opens an exclusive window. While that window is open, a core request beats a debug request that arrives in the same cycle, so the debugger does not get between the two halves of an atomic read-modify-write.

Top module: `ahb_dport_arb`

## Requirements
- R1: `htrans` is 2 (NSEQ) in every cycle where a transfer is presented and 0 (IDLE) otherwise. `hburst` is always 0 and `hmastlock` is always 0.
- R2: During a presented transfer, `haddr` and `hwrite` come from the granted requester, and `hsize` is that requester's 2-bit size (0 byte, 1 halfword, 2 word) zero-extended to 3 bits.
- R3: During a presented transfer, `hprot[3:2]` is 0 and `hprot[0]` is 1. `hprot[1]` equals `corePriv` for a core transfer and is 1 for a debug transfer.
- R4: `hmaster` is 0x00 for a core transfer and 0x01 for a debug transfer. `hexcl` equals `coreExcl` on a core transfer and is 0 on a debug transfer.
- R5: In each data phase, `hwdata` holds the data captured at acceptance. For a byte access, bits 7:0 are copied into all four lanes. For a halfword access, bits 15:0 are copied into both halves. A word is passed unchanged. The value stays stable while `hready` is low.
- R6: When only one requester is valid, that requester is granted. When both are valid, debug is granted unless the core's exclusive window is open, and then the core is granted. An accepted core transfer with `coreExcl`=1 and `coreWrite`=0 opens the window. Any other accepted core transfer closes it.
- R7: A transfer presented in a cycle with `hready` low is presented again from the same requester in the next cycle.
- R8: `coreRdy` is high exactly in the cycles where a core transfer is presented with `hready` high, which means its address phase is accepted.
- R9: When a data phase completes (`hready` high), only its owner sees a response. For the core this is `coreRspVld` with `coreRdata`=`hrdata` and `coreExOkay`=`hexokay`. For debug it is `dbgRdy` with `dbgRdata`=`hrdata`. The other requester's response outputs and read data are 0.
- R10: A debug request is not granted while a debug data phase is in progress, including the cycle in which that phase completes.
- R11: An error follows a two-cycle response. In the first cycle (`hready` low, `hresp` high) no response is raised. In the second cycle the owner's response is raised together with `coreErr` or `dbgErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the AHB bus |
| rstN | input | 1 | Asynchronous active-low reset |
| coreVld | input | 1 | Core request valid; held until `coreRdy` |
| coreRdy | output | 1 | Core address phase accepted this cycle |
| coreAddr | input | 32 | Core byte address, naturally aligned |
| coreWrite | input | 1 | Core write (1) or read (0) |
| coreSize | input | 2 | Core size: 0 byte, 1 halfword, 2 word |
| coreExcl | input | 1 | Core exclusive access |
| corePriv | input | 1 | Core privileged (1) or user (0) access |
| coreWdata | input | 32 | Core write data, low-aligned |
| coreRspVld | output | 1 | Core data phase completed |
| coreErr | output | 1 | Core transfer ended with an error |
| coreExOkay | output | 1 | Exclusive-okay status for the core transfer |
| coreRdata | output | 32 | Read data to the core |
| dbgVld | input | 1 | Debug request valid; held until `dbgRdy` |
| dbgAddr | input | 32 | Debug byte address, naturally aligned |
| dbgWrite | input | 1 | Debug write (1) or read (0) |
| dbgSize | input | 2 | Debug size: 0 byte, 1 halfword, 2 word |
| dbgWdata | input | 32 | Debug write data, low-aligned |
| dbgRdy | output | 1 | Debug data phase completed |
| dbgErr | output | 1 | Debug transfer ended with an error |
| dbgRdata | output | 32 | Read data to the debugger |
| haddr | output | 32 | AHB address |
| hwrite | output | 1 | AHB write flag |
| htrans | output | 2 | AHB transfer type (IDLE or NSEQ) |
| hsize | output | 3 | AHB transfer size |
| hburst | output | 3 | AHB burst type, fixed SINGLE |
| hprot | output | 4 | AHB protection bits |
| hmastlock | output | 1 | AHB locked transfer, fixed 0 |
| hmaster | output | 8 | AHB manager ID |
| hexcl | output | 1 | AHB exclusive transfer |
| hwdata | output | 32 | AHB write data |
| hready | input | 1 | AHB transfer done / data phase extend |
| hresp | input | 1 | AHB error response |
| hexokay | input | 1 | AHB exclusive success |
| hrdata | input | 32 | AHB read data |

## Verification
The address-phase outputs and `coreRdy` depend combinationally on the inputs of the same cycle. `hwdata` appears in the cycle after acceptance and stays there until `hready` rises. Completion, error, exclusive status and read data appear in the cycle where the data phase sees `hready` high, which is at least one cycle after acceptance and two cycles for an error. The bench changes inputs on the falling edge and samples all outputs shortly afterwards. It compares them against a reference model whose state advances as if at the next rising edge, so every value is checked in the cycle in which it is due.

// File: rtl/ahbdp_pkg.sv
package ahbdp_pkg;

  localparam logic [1:0] TRANS_IDLE = 2'b00;
  localparam logic [1:0] TRANS_NSEQ = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    logic issue;      // a transfer is presented this cycle
    logic selDbg;     // presented transfer belongs to debug
    logic accept;     // address phase taken this cycle
    logic dphActive;  // a data phase is in progress
    logic dphDbg;     // that data phase belongs to debug
  } dpStrobe_t;

endpackage

// File: rtl/ahbdp_ctrl.sv
module ahbdp_ctrl
  import ahbdp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      coreVld,
  input  logic      coreExcl,
  input  logic      coreWrite,
  input  logic      dbgVld,
  input  logic      hready,
  output dpStrobe_t st,
  output logic      coreRdy
);

  logic holdVld, holdDbg;
  logic exclOpen;
  logic dphActive, dphDbg;
  logic dbgOk, issue, pickDbg, accept;

  // Grant selection: a stalled address phase keeps its owner
  always_comb begin
    dbgOk = dbgVld && !(dphActive && dphDbg);
    if (holdVld) begin
      issue   = 1'b1;
      pickDbg = holdDbg;
    end else if (dbgOk && (!coreVld || !exclOpen)) begin
      issue   = 1'b1;
      pickDbg = 1'b1;
    end else begin
      issue   = coreVld;
      pickDbg = 1'b0;
    end
  end

  assign accept  = issue && hready;
  assign coreRdy = accept && !pickDbg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdVld   <= 1'b0;
      holdDbg   <= 1'b0;
      exclOpen  <= 1'b0;
      dphActive <= 1'b0;
      dphDbg    <= 1'b0;
    end else begin
      holdVld <= issue && !hready;
      holdDbg <= issue && pickDbg && !hready;
      if (hready) begin
        dphActive <= issue;
        dphDbg    <= issue && pickDbg;
      end
      if (accept && !pickDbg)
        exclOpen <= coreExcl && !coreWrite;
    end
  end

  always_comb begin
    st.issue     = issue;
    st.selDbg    = pickDbg;
    st.accept    = accept;
    st.dphActive = dphActive;
    st.dphDbg    = dphDbg;
  end

  // R7: a stalled address phase is presented again by the same owner
  p_grant_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !hready) |=> (issue && (pickDbg == $past(pickDbg))));

  // R10: no second debug grant while debug owns the data phase
  p_dbg_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dphActive && dphDbg) |-> !(issue && pickDbg));

  // R6: open exclusive window keeps a waiting core ahead of debug
  p_excl_priority_r6: assert property (@(posedge clk) disable iff (!rstN)
    (exclOpen && coreVld && !holdVld) |-> (issue && !pickDbg));

endmodule

// File: rtl/ahbdp_datapath.sv
module ahbdp_datapath
  import ahbdp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MID_W  = 8,
  parameter logic [MID_W-1:0] MID_CORE = 8'h00,
  parameter logic [MID_W-1:0] MID_DBG  = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic              coreWrite,
  input  logic [1:0]        coreSize,
  input  logic              coreExcl,
  input  logic              corePriv,
  input  logic [DATA_W-1:0] coreWdata,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic              dbgWrite,
  input  logic [1:0]        dbgSize,
  input  logic [DATA_W-1:0] dbgWdata,
  input  logic              hready,
  input  logic              hresp,
  input  logic              hexokay,
  input  logic [DATA_W-1:0] hrdata,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [3:0]        hprot,
  output logic [MID_W-1:0]  hmaster,
  output logic              hexcl,
  output logic [DATA_W-1:0] hwdata,
  output logic              coreRspVld,
  output logic              coreErr,
  output logic              coreExOkay,
  output logic [DATA_W-1:0] coreRdata,
  output logic              dbgRdy,
  output logic              dbgErr,
  output logic [DATA_W-1:0] dbgRdata
);

  localparam int LANES = DATA_W / 8;

  logic [1:0]        selSize;
  logic [DATA_W-1:0] selWdata;
  logic [DATA_W-1:0] replData;
  logic [DATA_W-1:0] wdataQ;
  logic              phaseDone;

  assign selSize  = st.selDbg ? dbgSize  : coreSize;
  assign selWdata = st.selDbg ? dbgWdata : coreWdata;

  // Address phase
  assign haddr   = st.selDbg ? dbgAddr  : coreAddr;
  assign hwrite  = st.selDbg ? dbgWrite : coreWrite;
  assign hsize   = {1'b0, selSize};
  assign hprot   = {2'b00, st.selDbg | corePriv, 1'b1};
  assign hmaster = st.selDbg ? MID_DBG : MID_CORE;
  assign hexcl   = st.issue && !st.selDbg && coreExcl;

  // Lane replication for narrow writes
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign replData[l*8 +: 8] =
      (selSize == 2'd0) ? selWdata[7:0] :
      (selSize == 2'd1) ? selWdata[(l % 2)*8 +: 8] :
                          selWdata[l*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          wdataQ <= '0;
    else if (st.accept) wdataQ <= replData;
  end

  assign hwdata = wdataQ;

  // Response routing to the data-phase owner
  assign phaseDone  = st.dphActive && hready;
  assign coreRspVld = phaseDone && !st.dphDbg;
  assign coreErr    = coreRspVld && hresp;
  assign coreExOkay = coreRspVld && hexokay;
  assign coreRdata  = coreRspVld ? hrdata : '0;
  assign dbgRdy     = phaseDone && st.dphDbg;
  assign dbgErr     = dbgRdy && hresp;
  assign dbgRdata   = dbgRdy ? hrdata : '0;

  // R5: write data does not move during a stalled data phase
  p_wdata_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.dphActive && !hready) |=> $stable(hwdata));

  // R9: never a response to both requesters at once
  p_single_owner_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(coreRspVld && dbgRdy));

endmodule

// File: rtl/ahb_dport_arb.sv
module ahb_dport_arb
  import ahbdp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MID_W  = 8,
  parameter logic [MID_W-1:0] MID_CORE = 8'h00,
  parameter logic [MID_W-1:0] MID_DBG  = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreVld,
  output logic              coreRdy,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic              coreWrite,
  input  logic [1:0]        coreSize,
  input  logic              coreExcl,
  input  logic              corePriv,
  input  logic [DATA_W-1:0] coreWdata,
  output logic              coreRspVld,
  output logic              coreErr,
  output logic              coreExOkay,
  output logic [DATA_W-1:0] coreRdata,
  input  logic              dbgVld,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic              dbgWrite,
  input  logic [1:0]        dbgSize,
  input  logic [DATA_W-1:0] dbgWdata,
  output logic              dbgRdy,
  output logic              dbgErr,
  output logic [DATA_W-1:0] dbgRdata,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [1:0]        htrans,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [3:0]        hprot,
  output logic              hmastlock,
  output logic [MID_W-1:0]  hmaster,
  output logic              hexcl,
  output logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  input  logic              hresp,
  input  logic              hexokay,
  input  logic [DATA_W-1:0] hrdata
);

  dpStrobe_t st;

  ahbdp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .coreVld  (coreVld),
    .coreExcl (coreExcl),
    .coreWrite(coreWrite),
    .dbgVld   (dbgVld),
    .hready   (hready),
    .st       (st),
    .coreRdy  (coreRdy)
  );

  ahbdp_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MID_W   (MID_W),
    .MID_CORE(MID_CORE),
    .MID_DBG (MID_DBG)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .coreAddr  (coreAddr),
    .coreWrite (coreWrite),
    .coreSize  (coreSize),
    .coreExcl  (coreExcl),
    .corePriv  (corePriv),
    .coreWdata (coreWdata),
    .dbgAddr   (dbgAddr),
    .dbgWrite  (dbgWrite),
    .dbgSize   (dbgSize),
    .dbgWdata  (dbgWdata),
    .hready    (hready),
    .hresp     (hresp),
    .hexokay   (hexokay),
    .hrdata    (hrdata),
    .haddr     (haddr),
    .hwrite    (hwrite),
    .hsize     (hsize),
    .hprot     (hprot),
    .hmaster   (hmaster),
    .hexcl     (hexcl),
    .hwdata    (hwdata),
    .coreRspVld(coreRspVld),
    .coreErr   (coreErr),
    .coreExOkay(coreExOkay),
    .coreRdata (coreRdata),
    .dbgRdy    (dbgRdy),
    .dbgErr    (dbgErr),
    .dbgRdata  (dbgRdata)
  );

  assign htrans    = st.issue ? TRANS_NSEQ : TRANS_IDLE;
  assign hburst    = 3'b000;
  assign hmastlock = 1'b0;

  // R1: only IDLE or NSEQ ever leaves the port
  p_trans_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == TRANS_IDLE) || (htrans == TRANS_NSEQ));

  // R4: debug transfers are privileged and never exclusive
  p_dbg_attrs_r4: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == TRANS_NSEQ && hmaster == MID_DBG) |-> (hprot[1] && !hexcl));

  // R8: core acceptance only with a core-owned NSEQ and hready high
  p_core_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    coreRdy |-> (htrans == TRANS_NSEQ && hmaster == MID_CORE && hready));

endmodule

// File: tb/ahb_dport_arb_test.sv
module ahb_dport_arb_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        coreVld, coreWrite, coreExcl, corePriv;
  logic [1:0]  coreSize;
  logic [31:0] coreAddr, coreWdata;
  logic        coreRdy, coreRspVld, coreErr, coreExOkay;
  logic [31:0] coreRdata;
  logic        dbgVld, dbgWrite;
  logic [1:0]  dbgSize;
  logic [31:0] dbgAddr, dbgWdata;
  logic        dbgRdy, dbgErr;
  logic [31:0] dbgRdata;
  logic [31:0] haddr, hwdata, hrdata;
  logic        hwrite, hmastlock, hexcl, hready, hresp, hexokay;
  logic [1:0]  htrans;
  logic [2:0]  hsize, hburst;
  logic [3:0]  hprot;
  logic [7:0]  hmaster;

  always #4 clk = ~clk;

  ahb_dport_arb uut (
    .clk(clk), .rstN(rstN),
    .coreVld(coreVld), .coreRdy(coreRdy), .coreAddr(coreAddr),
    .coreWrite(coreWrite), .coreSize(coreSize), .coreExcl(coreExcl),
    .corePriv(corePriv), .coreWdata(coreWdata), .coreRspVld(coreRspVld),
    .coreErr(coreErr), .coreExOkay(coreExOkay), .coreRdata(coreRdata),
    .dbgVld(dbgVld), .dbgAddr(dbgAddr), .dbgWrite(dbgWrite),
    .dbgSize(dbgSize), .dbgWdata(dbgWdata), .dbgRdy(dbgRdy),
    .dbgErr(dbgErr), .dbgRdata(dbgRdata),
    .haddr(haddr), .hwrite(hwrite), .htrans(htrans), .hsize(hsize),
    .hburst(hburst), .hprot(hprot), .hmastlock(hmastlock),
    .hmaster(hmaster), .hexcl(hexcl), .hwdata(hwdata),
    .hready(hready), .hresp(hresp), .hexokay(hexokay), .hrdata(hrdata)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  // reference model state
  bit          mHold, mHoldDbg, mExcl, mDph, mDphDbg, errPend;
  logic [31:0] mWdata;
  int nExclBlock = 0, nDbgWin = 0, nDbgBusy = 0, nHold = 0, nErr = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] repl(input logic [31:0] d, input logic [1:0] s);
    case (s)
      2'd0:    return {4{d[7:0]}};
      2'd1:    return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] alignAddr(input logic [31:0] a, input logic [1:0] s);
    return a & ~((32'd1 << s) - 32'd1);
  endfunction

  task automatic oneCycle(input int pc, input int pd, input int px,
                          input int pw, input int perr);
    bit eIssue, eSel, dbgOk, eDone, errFirst;
    logic [31:0] eAddr;
    logic [1:0]  eSize;
    logic        eWrite;
    @(negedge clk);
    // subordinate response
    if (errPend) begin
      hready = 1'b1; hresp = 1'b1;
    end else if (mDph && ($urandom % 100) < perr) begin
      hready = 1'b0; hresp = 1'b1;
    end else begin
      hresp  = 1'b0;
      hready = mDph ? (($urandom % 100) >= pw) : 1'b1;
    end
    errFirst = mDph && hresp && !hready;
    hexokay  = 1'($urandom);
    hrdata   = $urandom;
    // requesters; a stalled owner keeps its request
    if (!(mHold && !mHoldDbg)) begin
      coreVld   = ($urandom % 100) < pc;
      coreSize  = 2'($urandom % 3);
      coreAddr  = alignAddr($urandom, coreSize);
      coreWrite = 1'($urandom);
      coreExcl  = ($urandom % 100) < px;
      corePriv  = 1'($urandom);
      coreWdata = $urandom;
    end
    if (!(mHold && mHoldDbg)) begin
      dbgVld   = ($urandom % 100) < pd;
      dbgSize  = 2'($urandom % 3);
      dbgAddr  = alignAddr($urandom, dbgSize);
      dbgWrite = 1'($urandom);
      dbgWdata = $urandom;
    end
    #1;
    // expected grant
    dbgOk = dbgVld && !(mDph && mDphDbg);
    if (mHold) begin eIssue = 1'b1; eSel = mHoldDbg; end
    else if (dbgOk && (!coreVld || !mExcl)) begin eIssue = 1'b1; eSel = 1'b1; end
    else begin eIssue = coreVld; eSel = 1'b0; end
    if (!mHold && dbgOk && coreVld && mExcl)  nExclBlock++;
    if (!mHold && dbgOk && coreVld && !mExcl) nDbgWin++;
    if (!mHold && dbgVld && mDph && mDphDbg)  nDbgBusy++;
    if (mHold)    nHold++;
    if (errFirst) nErr++;

    chk("R1", "htrans", htrans, eIssue ? 2'd2 : 2'd0);
    chk("R1", "hburst/hmastlock", {hburst, hmastlock}, 4'd0);
    chk(mHold ? "R7" : "R6", "debug grant",
        (htrans == 2'd2) && (hmaster == 8'h01), eIssue && eSel);
    if (!mHold && mDph && mDphDbg)
      chk("R10", "debug regrant", (htrans == 2'd2) && (hmaster == 8'h01), 1'b0);
    if (eIssue) begin
      eAddr  = eSel ? dbgAddr  : coreAddr;
      eSize  = eSel ? dbgSize  : coreSize;
      eWrite = eSel ? dbgWrite : coreWrite;
      chk("R2", "haddr", haddr, eAddr);
      chk("R2", "hwrite", hwrite, eWrite);
      chk("R2", "hsize", hsize, {1'b0, eSize});
      chk("R3", "hprot", hprot, {2'b00, eSel | corePriv, 1'b1});
      chk("R4", "hmaster", hmaster, eSel ? 8'h01 : 8'h00);
      chk("R4", "hexcl", hexcl, !eSel && coreExcl);
    end
    chk("R8", "coreRdy", coreRdy, eIssue && hready && !eSel);
    if (mDph) chk("R5", "hwdata", hwdata, mWdata);
    eDone = mDph && hready;
    chk(errFirst ? "R11" : "R9", "coreRspVld", coreRspVld, eDone && !mDphDbg);
    chk(errFirst ? "R11" : "R9", "dbgRdy", dbgRdy, eDone && mDphDbg);
    chk("R9", "coreRdata", coreRdata, (eDone && !mDphDbg) ? hrdata : 32'd0);
    chk("R9", "dbgRdata", dbgRdata, (eDone && mDphDbg) ? hrdata : 32'd0);
    chk("R9", "coreExOkay", coreExOkay, eDone && !mDphDbg && hexokay);
    chk("R11", "coreErr", coreErr, eDone && !mDphDbg && hresp);
    chk("R11", "dbgErr", dbgErr, eDone && mDphDbg && hresp);

    // advance model as at the next rising edge
    if (eIssue && hready) begin
      mWdata = repl(eSel ? dbgWdata : coreWdata, eSel ? dbgSize : coreSize);
      if (!eSel) mExcl = coreExcl && !coreWrite;
    end
    if (hready) begin mDph = eIssue; mDphDbg = eIssue && eSel; end
    mHoldDbg = eIssue && eSel && !hready;
    mHold    = eIssue && !hready;
    errPend  = errFirst;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rstN = 1'b0;
    coreVld = 0; coreWrite = 0; coreExcl = 0; corePriv = 0; coreSize = 0;
    coreAddr = 0; coreWdata = 0;
    dbgVld = 0; dbgWrite = 0; dbgSize = 0; dbgAddr = 0; dbgWdata = 0;
    hready = 1; hresp = 0; hexokay = 0; hrdata = 32'hdead_beef;
    mHold = 0; mHoldDbg = 0; mExcl = 0; mDph = 0; mDphDbg = 0; errPend = 0;
    mWdata = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset htrans", htrans, 2'd0);
    chk("R8", "reset coreRdy", coreRdy, 1'b0);
    chk("R9", "reset responses", {coreRspVld, dbgRdy, coreRdata, dbgRdata}, 66'd0);
    chk("R5", "reset hwdata", hwdata, 32'd0);
    rstN = 1'b1;
    // distinct stimulus mixes: core, debug, exclusive, wait, error percentages
    for (int c = 0; c < 600; c++) oneCycle(80, 0, 30, 30, 0);
    for (int c = 0; c < 600; c++) oneCycle(0, 80, 0, 40, 10);
    for (int c = 0; c < 800; c++) oneCycle(70, 60, 50, 40, 8);
    for (int c = 0; c < 600; c++) oneCycle(95, 95, 20, 0, 0);
    for (int c = 0; c < 600; c++) oneCycle(50, 50, 60, 60, 15);
    // corner cases that must have been reached
    chk("R6", "exclusive window blocked debug", nExclBlock > 0, 1'b1);
    chk("R6", "debug won a tie", nDbgWin > 0, 1'b1);
    chk("R7", "stalled address phase held", nHold > 0, 1'b1);
    chk("R10", "debug busy window seen", nDbgBusy > 0, 1'b1);
    chk("R11", "error responses seen", nErr > 0, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule